// File: doc/BRIEF.md
# Supervisor Timer Compare Register Unit

This unit keeps the 64-bit compare value of the supervisor timer. Software reaches it through one CSR access port. A select line picks either the low-half address or the high-half address. The unit compares the free-running 64-bit time input against the stored value and drives the supervisor timer interrupt-pending bit straight from that comparison. The rest of the CSR file supplies the privilege level, the register width mode, the enable strap, the time-source flag, the counter-enable timer bit and the environment-config timer-compare enable bit.

Access is checked on every request. A rejected access raises an illegal-instruction flag, writes nothing and returns zero. In 32-bit mode each half is written on its own. In 64-bit mode a single low-half write replaces the whole register. While the hardware owns the pending bit, the unit also trims the mask used for software writes to the pending-interrupt register. This stops machine-mode software from changing the supervisor and virtual-supervisor timer pending bits (positions 5 and 6).

Top module: `stc_unit`

## Requirements
- R1: An access (csr_valid_i=1) raises illegal_o when ext_en_i=0 or time_avail_i=0, whatever the other inputs are.
- R2: With ext_en_i=1 and time_avail_i=1, a machine-mode access (priv_i=2'b11) is legal regardless of cnt_tm_i and stce_i, except as R4 states.
- R3: Below machine mode, an access is illegal unless cnt_tm_i=1 and stce_i=1. A user-mode access (priv_i=2'b00) is always illegal. Supervisor is priv_i=2'b01.
- R4: A high-half access (csr_hi_i=1) is illegal when xlen32_i=0.
- R5: A legal low-half write in 32-bit mode (xlen32_i=1) replaces bits 31:0 and keeps bits 63:32. In 64-bit mode it replaces all 64 bits. A low-half read returns the zero-extended bits 31:0 in 32-bit mode and the full value in 64-bit mode.
- R6: A legal high-half write replaces bits 63:32 with csr_wdata_i[31:0] and keeps bits 31:0. A high-half read returns bits 63:32, zero-extended.
- R7: stip_o is 1 exactly when ext_en_i=1, stce_i=1 and time_i is greater than or equal to the stored value (unsigned). It follows time_i combinationally. A write takes effect on the clock edge that accepts it, so stip_o reflects the new value from the next cycle.
- R8: When stce_i=0 or ext_en_i=0, stip_o is 0. The pending bit is then left to the normal software write path.
- R9: mip_mask_o equals mip_mask_i with bits 5 and 6 cleared when ext_en_i=1, priv_i=2'b11 and stce_i=1. Otherwise mip_mask_o equals mip_mask_i.
- R10: After reset the stored value is all ones, so no interrupt is pending unless time_i is all ones.
- R11: An illegal access, or a cycle with no access, leaves the stored value unchanged. csr_rdata_o is zero whenever there is no legal read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| priv_i | input | 2 | Current privilege: 00 user, 01 supervisor, 11 machine |
| xlen32_i | input | 1 | 1 selects 32-bit register width mode |
| ext_en_i | input | 1 | Timer-compare feature strap |
| time_avail_i | input | 1 | A time source is present |
| cnt_tm_i | input | 1 | Counter-enable timer bit |
| stce_i | input | 1 | Environment-config timer-compare enable |
| time_i | input | 64 | Free-running time value |
| csr_valid_i | input | 1 | Access request this cycle |
| csr_hi_i | input | 1 | 1 selects the high-half address |
| csr_we_i | input | 1 | 1 for a write, 0 for a read |
| csr_wdata_i | input | 64 | Write data |
| csr_rdata_o | output | 64 | Read data (zero unless a legal read) |
| illegal_o | output | 1 | Access rejected |
| stip_o | output | 1 | Supervisor timer interrupt pending |
| mip_mask_i | input | 64 | Writable mask proposed for a software write to the pending register |
| mip_mask_o | output | 64 | Mask after timer bits are withheld |

## Verification
The assertions assume that priv_i never takes the reserved value 2'b10. They also assume csr_hi_i, csr_we_i and csr_wdata_i matter only while csr_valid_i is high. The bench draws privilege only from the three defined levels. It keeps the inputs steady between the falling edge where it drives them and the rising edge that consumes them. Time values are aimed at the stored value minus one, equal and plus one. They also cover values across the sign bit, so the unsigned boundary gets exercised while every input stays inside those assumptions.

// File: rtl/stc_pkg.sv
package stc_pkg;
  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_S = 2'b01;
  localparam logic [1:0] PRIV_M = 2'b11;
  // architectural pending-register positions decoded by the neighbour
  localparam int unsigned STIP_POS  = 5;
  localparam int unsigned VSTIP_POS = 6;
endpackage

// File: rtl/stc_access.sv
module stc_access
  import stc_pkg::*;
(
  input  logic       valid_i,
  input  logic       hi_i,
  input  logic       we_i,
  input  logic [1:0] priv_i,
  input  logic       xlen32_i,
  input  logic       ext_en_i,
  input  logic       time_avail_i,
  input  logic       cnt_tm_i,
  input  logic       stce_i,
  output logic       illegal_o,
  output logic       wr_lo_o,
  output logic       wr_hi_o,
  output logic       rd_ok_o
);
  logic present, width_ok, priv_ok, legal;

  assign present  = ext_en_i & time_avail_i;
  assign width_ok = ~hi_i | xlen32_i;
  // machine always passes; lower levels need both enables and at least S
  assign priv_ok  = (priv_i == PRIV_M) |
                    (cnt_tm_i & stce_i & (priv_i != PRIV_U));
  assign legal    = present & width_ok & priv_ok;

  assign illegal_o = valid_i & ~legal;
  assign wr_lo_o   = valid_i & legal & we_i & ~hi_i;
  assign wr_hi_o   = valid_i & legal & we_i & hi_i;
  assign rd_ok_o   = valid_i & legal & ~we_i;
endmodule

// File: rtl/stc_cmp_reg.sv
module stc_cmp_reg #(
  parameter int unsigned TW = 64,
  localparam int unsigned HW = TW / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic          xlen32_i,
  input  logic [TW-1:0] wdata_i,
  output logic [TW-1:0] cmp_o
);
  for (genvar h = 0; h < 2; h++) begin : g_half
    logic          we_h;
    logic [HW-1:0] src_h;
    logic [HW-1:0] q_h;

    if (h == 0) begin : g_lo
      assign we_h  = wr_lo_i;
      assign src_h = wdata_i[HW-1:0];
    end else begin : g_hi
      // upper half: own address, or a full-width low write
      assign we_h  = wr_hi_i | (wr_lo_i & ~xlen32_i);
      assign src_h = wr_hi_i ? wdata_i[HW-1:0] : wdata_i[TW-1:HW];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   q_h <= '1;
      else if (we_h) q_h <= src_h;
    end

    assign cmp_o[h*HW +: HW] = q_h;
  end

  AST_HI_KEEPS_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi_i |=> $stable(cmp_o[HW-1:0])); // R6
  AST_LO32_KEEPS_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lo_i && xlen32_i) |=> $stable(cmp_o[TW-1:HW])); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_lo_i || wr_hi_i) |=> $stable(cmp_o)); // R11
endmodule

// File: rtl/stc_irq.sv
module stc_irq
  import stc_pkg::*;
#(
  parameter int unsigned TW = 64,
  parameter int unsigned MW = 64
) (
  input  logic          ext_en_i,
  input  logic          stce_i,
  input  logic [1:0]    priv_i,
  input  logic [TW-1:0] time_i,
  input  logic [TW-1:0] cmp_i,
  input  logic [MW-1:0] mask_i,
  output logic          stip_o,
  output logic [MW-1:0] mask_o
);
  logic          hw_owned;
  logic [MW-1:0] lock;

  assign hw_owned = ext_en_i & stce_i;
  assign stip_o   = hw_owned & (time_i >= cmp_i);

  always_comb begin
    lock = '0;
    lock[STIP_POS]  = 1'b1;
    lock[VSTIP_POS] = 1'b1;
  end

  assign mask_o = (hw_owned && priv_i == PRIV_M) ? (mask_i & ~lock) : mask_i;
endmodule

// File: rtl/stc_unit.sv
module stc_unit
  import stc_pkg::*;
#(
  parameter int unsigned TW = 64,
  parameter int unsigned MW = 64,
  localparam int unsigned HW = TW / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    priv_i,
  input  logic          xlen32_i,
  input  logic          ext_en_i,
  input  logic          time_avail_i,
  input  logic          cnt_tm_i,
  input  logic          stce_i,
  input  logic [TW-1:0] time_i,
  input  logic          csr_valid_i,
  input  logic          csr_hi_i,
  input  logic          csr_we_i,
  input  logic [TW-1:0] csr_wdata_i,
  output logic [TW-1:0] csr_rdata_o,
  output logic          illegal_o,
  output logic          stip_o,
  input  logic [MW-1:0] mip_mask_i,
  output logic [MW-1:0] mip_mask_o
);
  logic          wr_lo, wr_hi, rd_ok;
  logic [TW-1:0] cmp;

  stc_access u_acc (
    .valid_i(csr_valid_i), .hi_i(csr_hi_i), .we_i(csr_we_i), .priv_i(priv_i),
    .xlen32_i(xlen32_i), .ext_en_i(ext_en_i), .time_avail_i(time_avail_i),
    .cnt_tm_i(cnt_tm_i), .stce_i(stce_i), .illegal_o(illegal_o),
    .wr_lo_o(wr_lo), .wr_hi_o(wr_hi), .rd_ok_o(rd_ok)
  );

  stc_cmp_reg #(.TW(TW)) u_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_lo_i(wr_lo), .wr_hi_i(wr_hi),
    .xlen32_i(xlen32_i), .wdata_i(csr_wdata_i), .cmp_o(cmp)
  );

  stc_irq #(.TW(TW), .MW(MW)) u_irq (
    .ext_en_i(ext_en_i), .stce_i(stce_i), .priv_i(priv_i), .time_i(time_i),
    .cmp_i(cmp), .mask_i(mip_mask_i), .stip_o(stip_o), .mask_o(mip_mask_o)
  );

  always_comb begin
    csr_rdata_o = '0;
    if (rd_ok) begin
      if (csr_hi_i)      csr_rdata_o[HW-1:0] = cmp[TW-1:HW];
      else if (xlen32_i) csr_rdata_o[HW-1:0] = cmp[HW-1:0];
      else               csr_rdata_o = cmp;
    end
  end

  AST_GATE_OFF_ILLEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_valid_i && !(ext_en_i && time_avail_i)) |-> illegal_o); // R1
  AST_MACHINE_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_valid_i && ext_en_i && time_avail_i && priv_i == PRIV_M &&
     (!csr_hi_i || xlen32_i)) |-> !illegal_o); // R2
  AST_USER_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_valid_i && priv_i == PRIV_U) |-> illegal_o); // R3
  AST_HI_WIDE_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_valid_i && csr_hi_i && !xlen32_i) |-> illegal_o); // R4
  AST_STIP_MEETS_CMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stip_o |-> (time_i >= cmp)); // R7
  AST_STIP_NEEDS_STCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stce_i && ext_en_i) |-> !stip_o); // R8
  AST_MASK_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_en_i && stce_i && priv_i == PRIV_M) |->
      (!mip_mask_o[STIP_POS] && !mip_mask_o[VSTIP_POS])); // R9
  AST_ILLEGAL_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> $stable(cmp)); // R11
  AST_ILLEGAL_NO_RDATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (csr_rdata_o == '0)); // R11
endmodule

// File: tb/sim_stc_unit.sv
module sim_stc_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  priv_i = 2'b11;
  logic        xlen32_i = 1'b0, ext_en_i = 1'b1, time_avail_i = 1'b1;
  logic        cnt_tm_i = 1'b0, stce_i = 1'b0;
  logic [63:0] time_i = '0;
  logic        csr_valid_i = 1'b0, csr_hi_i = 1'b0, csr_we_i = 1'b0;
  logic [63:0] csr_wdata_i = '0, csr_rdata_o;
  logic        illegal_o, stip_o;
  logic [63:0] mip_mask_i = '1, mip_mask_o;

  int checks = 0;
  int errors = 0;
  logic [63:0] ref_cmp;

  always #10 clk_i = ~clk_i;

  stc_unit u0 (.*);

  function automatic bit m_illegal();
    if (!csr_valid_i) return 0;
    if (!ext_en_i || !time_avail_i) return 1;
    if (csr_hi_i && !xlen32_i) return 1;
    if (priv_i == 2'b11) return 0;
    if (!(cnt_tm_i && stce_i)) return 1;
    if (priv_i == 2'b00) return 1;
    return 0;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // inputs set before call (after a falling edge); checks, then consumes one edge
  task automatic step(input string tag);
    bit ill;
    logic [63:0] exp_rd, exp_mask;
    #5;
    ill = m_illegal();
    exp_rd = '0;
    if (csr_valid_i && !ill && !csr_we_i) begin
      if (csr_hi_i)      exp_rd = {32'h0, ref_cmp[63:32]};
      else if (xlen32_i) exp_rd = {32'h0, ref_cmp[31:0]};
      else               exp_rd = ref_cmp;
    end
    exp_mask = (ext_en_i && stce_i && priv_i == 2'b11) ? (mip_mask_i & ~64'h60) : mip_mask_i;
    chk({tag, " R1/R2/R3/R4 illegal"}, {63'h0, illegal_o}, {63'h0, ill});
    chk({tag, " R5/R6/R11 rdata"}, csr_rdata_o, exp_rd);
    chk({tag, " R7/R8 stip"}, {63'h0, stip_o},
        {63'h0, ext_en_i && stce_i && (time_i >= ref_cmp)});
    chk({tag, " R9 mask"}, mip_mask_o, exp_mask);
    @(posedge clk_i);
    if (csr_valid_i && !ill && csr_we_i) begin
      if (csr_hi_i)      ref_cmp[63:32] = csr_wdata_i[31:0];
      else if (xlen32_i) ref_cmp[31:0]  = csr_wdata_i[31:0];
      else               ref_cmp        = csr_wdata_i;
    end
    @(negedge clk_i);
  endtask

  task automatic acc(input logic [1:0] p, input bit x32, input bit hi, input bit we,
                     input logic [63:0] d, input string tag);
    priv_i = p; xlen32_i = x32; csr_hi_i = hi; csr_we_i = we; csr_wdata_i = d;
    csr_valid_i = 1'b1;
    step(tag);
    csr_valid_i = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    ref_cmp = '1;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    // R10: reset value all ones, no pending
    stce_i = 1'b1; time_i = 64'hFFFF_FFFF_FFFF_FFFE;
    step("R10 after reset");
    acc(2'b11, 0, 0, 0, '0, "R10 read reset value");
    // R2: machine allowed with enables clear
    stce_i = 0; cnt_tm_i = 0;
    acc(2'b11, 0, 0, 1, 64'h0000_0001_0000_0100, "R2 machine write");
    acc(2'b11, 0, 0, 0, '0, "R2 machine read");
    // R7 boundaries
    stce_i = 1;
    time_i = 64'h0000_0001_0000_00FF; step("R7 below");
    time_i = 64'h0000_0001_0000_0100; step("R7 equal");
    time_i = 64'h0000_0001_0000_0101; step("R7 above");
    // R8: stce clear keeps stip low
    stce_i = 0; step("R8 stce off");
    ext_en_i = 0; stce_i = 1; step("R8 ext off");
    // R1
    acc(2'b11, 0, 0, 1, 64'h5, "R1 ext off write");
    ext_en_i = 1; time_avail_i = 0;
    acc(2'b11, 1, 1, 1, 64'h5, "R1 no time write");
    time_avail_i = 1;
    // R4
    acc(2'b11, 0, 1, 1, 64'h7, "R4 hi in rv64");
    // R3
    cnt_tm_i = 1; stce_i = 1;
    acc(2'b00, 1, 0, 1, 64'h9, "R3 user write");
    acc(2'b01, 1, 0, 1, 64'h1234_5678_8000_0000, "R3 R5 sup lo32 write");
    acc(2'b01, 1, 0, 0, '0, "R5 lo32 read");
    cnt_tm_i = 0;
    acc(2'b01, 1, 0, 1, 64'h3, "R3 sup tm off");
    cnt_tm_i = 1; stce_i = 0;
    acc(2'b01, 1, 0, 1, 64'h3, "R3 sup stce off");
    stce_i = 1;
    // R6
    acc(2'b01, 1, 1, 1, 64'hAAAA_AAAA_8000_0000, "R6 hi write");
    acc(2'b01, 1, 1, 0, '0, "R6 hi read");
    acc(2'b11, 0, 0, 0, '0, "R6 full read");
    // R7 unsigned across sign bit
    time_i = 64'h7FFF_FFFF_FFFF_FFFF; step("R7 unsigned low");
    time_i = 64'hFFFF_FFFF_0000_0000; step("R7 unsigned high");
    // R9 masks
    mip_mask_i = 64'h0000_0000_0000_0FFF; priv_i = 2'b11; step("R9 locked");
    priv_i = 2'b01; step("R9 sup pass");
    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom % 3;
      priv_i = (r == 0) ? 2'b00 : (r == 1) ? 2'b01 : 2'b11;
      xlen32_i = $urandom % 2; ext_en_i = ($urandom % 8) != 0;
      time_avail_i = ($urandom % 8) != 0; cnt_tm_i = ($urandom % 4) != 0;
      stce_i = ($urandom % 4) != 0; csr_valid_i = ($urandom % 4) != 0;
      csr_hi_i = $urandom % 2; csr_we_i = $urandom % 2;
      csr_wdata_i = {$urandom, $urandom};
      mip_mask_i = {$urandom, $urandom};
      case ($urandom % 4)
        0: time_i = ref_cmp - 1;
        1: time_i = ref_cmp;
        2: time_i = ref_cmp + 1;
        default: time_i = {$urandom, $urandom};
      endcase
      step("mix");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule